// File: doc/BRIEF.md
# Lookup-Table FM Modulator

The block turns a stream of signed baseband samples into a frequency-modulated quadrature carrier. A 32-bit phase accumulator advances once for every accepted sample. The step is the carrier frequency word plus an offset that depends on the sample. To form the offset, the sample is first scaled by a maximum-deviation word. The result is then multiplied by a small integer sensitivity gain and clipped so that it never leaves plus or minus the deviation word. The top bits of the phase select an entry in two 1024-point tables, one holding a sine period and one holding a cosine period. The selected pair is presented as the I/Q output.

Configuration arrives on plain ports that the surrounding logic holds steady. Samples arrive with a valid strobe, and results leave with a valid strobe a fixed number of cycles later. When the strobe is low, the phase is held, so the output phase stays continuous across any gap in the input.

Top module: `fm_modulator_core`

## Requirements
- R1: While reset is low, out_valid is 0 and out_sin and out_cos are 0. The phase starts at zero, so the first output pair after reset is out_sin = 0 and out_cos = 1024.
- R2: out_valid is high exactly three clock cycles after in_valid was sampled high, and is low otherwise. Each accepted sample produces exactly one output pair.
- R3: out_sin equals trunc(1024·sin(2π·a/1024)), rounded toward zero. The address a is bits [31:22] of the phase that was in force when the sample was accepted.
- R4: out_cos equals trunc(1024·cos(2π·a/1024)), rounded toward zero, for the same address a as R3.
- R5: Each accepted sample x advances the phase by cfg_carrier + clip(((x·cfg_dev) >>> 11)·cfg_kf) modulo 2^32. Here x is 12-bit two's complement, cfg_dev is unsigned, cfg_kf is unsigned, and >>> is an arithmetic shift toward minus infinity.
- R6: The frequency offset added to the carrier word is clipped to the range [−cfg_dev, +cfg_dev].
- R7: While in_valid is low, the phase does not change and the value on in_sample has no effect.
- R8: The output pair for the n-th accepted sample uses the phase before that sample's own step. That phase is the sum of the steps of the samples accepted before it.
- R9: While out_valid is low, out_sin and out_cos keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Baseband sample strobe |
| in_sample | input | 12 | Signed baseband sample |
| cfg_carrier | input | 32 | Carrier phase step per sample |
| cfg_kf | input | 4 | Unsigned sensitivity gain |
| cfg_dev | input | 24 | Unsigned maximum-deviation word |
| out_valid | output | 1 | Output pair strobe |
| out_sin | output | 12 | Signed sine (Q) sample |
| out_cos | output | 12 | Signed cosine (I) sample |

## Verification
Several properties are checked on every cycle:
- the three-cycle valid latency;
- the clip on the offset against cfg_dev;
- the frozen phase during input gaps;
- the hold of the outputs while out_valid is low;
- the fact that every emitted pair lies in a thin ring around radius 1024.

Other behaviour can only be shown by the bench's scenarios, which compare every output pair against an arithmetic model:
- the exact truncated table values at each address;
- the step formula with its shift, gain and wraparound;
- the rule that a sample's own step is not yet applied to its output.

The scenarios sweep every 12-bit sample value under several carrier, gain and deviation settings, with and without gaps. They also include a walk through all 1024 table addresses.

// File: rtl/fmmod_pkg.sv
// Shared definitions for the FM modulator: waveform kind and the
// elaboration-time waveform point generator used to fill the tables.
package fmmod_pkg;

    localparam real PI_VAL = 3.141592653589793;

    typedef enum logic {
        WAVE_SIN = 1'b0,
        WAVE_COS = 1'b1
    } wave_kind_e;

    // One table point: scale * sin/cos(2*pi*k/depth), truncated toward zero.
    function automatic int wave_point(input int k, input int depth,
                                      input int scale, input bit use_cos);
        real ph;
        real v;
        ph = 2.0 * PI_VAL * real'(k) / real'(depth);
        v  = use_cos ? $cos(ph) : $sin(ph);
        return $rtoi(real'(scale) * v);
    endfunction

endpackage

// File: rtl/fmmod_dev_scale.sv
// Stage 1 of the modulator: multiplies the signed sample by the unsigned
// deviation word and drops SAMPLE_W-1 fraction bits (arithmetic shift), so a
// full-scale sample maps to roughly +/- cfg_dev. Result and strobe registered.
// Assumes cfg_dev is stable while samples are in flight.
module fmmod_dev_scale #(
    parameter int SAMPLE_W = 12,
    parameter int DEV_W    = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [SAMPLE_W-1:0]      in_sample,
    input  logic [DEV_W-1:0]         cfg_dev,
    output logic                     sc_valid,
    output logic signed [DEV_W+1:0]  sc_value
);

    localparam int PROD_W   = SAMPLE_W + DEV_W + 1;
    localparam int SHIFT    = SAMPLE_W - 1;
    localparam int SCALED_W = DEV_W + 2;

    logic signed [PROD_W-1:0] smp_ext;
    logic signed [PROD_W-1:0] dev_ext;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] shifted;

    // Sign-extend the sample, zero-extend the deviation, multiply and shift.
    always_comb begin
        smp_ext = {{(PROD_W-SAMPLE_W){in_sample[SAMPLE_W-1]}}, in_sample};
        dev_ext = {{(PROD_W-DEV_W){1'b0}}, cfg_dev};
        prod    = smp_ext * dev_ext;
        shifted = prod >>> SHIFT;
    end

    // Register the scaled value and its strobe; hold the value on gaps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sc_valid <= 1'b0;
            sc_value <= '0;
        end else begin
            sc_valid <= in_valid;
            if (in_valid) begin
                sc_value <= shifted[SCALED_W-1:0];
            end
        end
    end

endmodule

// File: rtl/fmmod_dev_clip.sv
// Combinational sensitivity gain and clip: multiplies the scaled sample by
// the unsigned gain cfg_kf and limits the result to [-cfg_dev, +cfg_dev].
// Assumes the gain product fits GAIN_W bits, which holds by width choice.
module fmmod_dev_clip #(
    parameter int DEV_W = 24,
    parameter int KF_W  = 4
) (
    input  logic signed [DEV_W+1:0] sc_value,
    input  logic [KF_W-1:0]         cfg_kf,
    input  logic [DEV_W-1:0]        cfg_dev,
    output logic signed [DEV_W:0]   step_offset
);

    localparam int SCALED_W = DEV_W + 2;
    localparam int GAIN_W   = SCALED_W + KF_W + 1;
    localparam int OFF_W    = DEV_W + 1;

    logic signed [GAIN_W-1:0] sc_ext;
    logic signed [GAIN_W-1:0] kf_ext;
    logic signed [GAIN_W-1:0] gain;
    logic signed [GAIN_W-1:0] lim;
    logic signed [OFF_W-1:0]  lim_o;

    // Apply the gain, then clip against the deviation word.
    always_comb begin
        sc_ext = {{(GAIN_W-SCALED_W){sc_value[SCALED_W-1]}}, sc_value};
        kf_ext = {{(GAIN_W-KF_W){1'b0}}, cfg_kf};
        gain   = sc_ext * kf_ext;
        lim    = {{(GAIN_W-DEV_W){1'b0}}, cfg_dev};
        lim_o  = {1'b0, cfg_dev};
        if (gain > lim) begin
            step_offset = lim_o;
        end else if (gain < -lim) begin
            step_offset = -lim_o;
        end else begin
            step_offset = gain[OFF_W-1:0];
        end
    end

endmodule

// File: rtl/fmmod_phase_acc.sv
// Stage 2 of the modulator: latches the table address from the current phase
// and then advances the phase by carrier + offset (modulo 2^PHASE_W). The
// phase only moves on a strobe, so it stays continuous across input gaps.
module fmmod_phase_acc #(
    parameter int PHASE_W = 32,
    parameter int ADDR_W  = 10,
    parameter int DEV_W   = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step_en,
    input  logic signed [DEV_W:0]   step_offset,
    input  logic [PHASE_W-1:0]      cfg_carrier,
    output logic [PHASE_W-1:0]      phase_q,
    output logic [ADDR_W-1:0]       addr_q,
    output logic                    addr_valid
);

    localparam int OFF_W = DEV_W + 1;

    logic [PHASE_W-1:0] step;

    // Per-sample phase step: carrier word plus sign-extended offset.
    always_comb begin
        step = cfg_carrier + {{(PHASE_W-OFF_W){step_offset[OFF_W-1]}}, step_offset};
    end

    // Capture the address of the pre-step phase, then advance the phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= '0;
            addr_q     <= '0;
            addr_valid <= 1'b0;
        end else begin
            addr_valid <= step_en;
            if (step_en) begin
                addr_q  <= phase_q[PHASE_W-1 -: ADDR_W];
                phase_q <= phase_q + step;
            end
        end
    end

endmodule

// File: rtl/fmmod_wave_rom.sv
// Registered waveform table of 2^ADDR_W points, one full period, each point
// AMP_SCALE*sin or cos of the point's phase truncated toward zero. The
// contents are computed at elaboration. The output holds when not read.
module fmmod_wave_rom
    import fmmod_pkg::*;
#(
    parameter int         ADDR_W    = 10,
    parameter int         AMP_W     = 12,
    parameter int         AMP_SCALE = 1024,
    parameter wave_kind_e KIND      = WAVE_SIN
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_en,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic signed [AMP_W-1:0]  rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic signed [AMP_W-1:0] table_q [DEPTH];

    // Fill the table from the waveform generator.
    initial begin
        for (int k = 0; k < DEPTH; k++) begin
            table_q[k] = AMP_W'(wave_point(k, DEPTH, AMP_SCALE, KIND == WAVE_COS));
        end
    end

    // Registered read with hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= table_q[rd_addr];
        end
    end

endmodule

// File: rtl/fm_modulator_core.sv
// FM modulator top: a deviation scale stage, then gain/clip and the phase
// accumulator, then a pair of registered sine/cosine tables. The latency
// from in_valid to out_valid is three cycles. Assumes cfg_* are static while
// samples are in flight.
module fm_modulator_core
    import fmmod_pkg::*;
#(
    parameter int SAMPLE_W  = 12,
    parameter int DEV_W     = 24,
    parameter int KF_W      = 4,
    parameter int PHASE_W   = 32,
    parameter int ADDR_W    = 10,
    parameter int AMP_W     = 12,
    parameter int AMP_SCALE = 1024
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [SAMPLE_W-1:0]     in_sample,
    input  logic [PHASE_W-1:0]      cfg_carrier,
    input  logic [KF_W-1:0]         cfg_kf,
    input  logic [DEV_W-1:0]        cfg_dev,
    output logic                    out_valid,
    output logic [AMP_W-1:0]        out_sin,
    output logic [AMP_W-1:0]        out_cos
);

    localparam int SCALED_W = DEV_W + 2;
    localparam int OFF_W    = DEV_W + 1;
    localparam int N_WAVES  = 2;

    logic                       scale_valid;
    logic signed [SCALED_W-1:0] scale_val;
    logic signed [OFF_W-1:0]    step_offset;
    logic [PHASE_W-1:0]         phase_acc;
    logic [ADDR_W-1:0]          rom_addr;
    logic                       rom_en;
    logic signed [AMP_W-1:0]    wave_q [N_WAVES];

    fmmod_dev_scale #(.SAMPLE_W(SAMPLE_W), .DEV_W(DEV_W)) u_scale (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .cfg_dev   (cfg_dev),
        .sc_valid  (scale_valid),
        .sc_value  (scale_val)
    );

    fmmod_dev_clip #(.DEV_W(DEV_W), .KF_W(KF_W)) u_clip (
        .sc_value    (scale_val),
        .cfg_kf      (cfg_kf),
        .cfg_dev     (cfg_dev),
        .step_offset (step_offset)
    );

    fmmod_phase_acc #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W), .DEV_W(DEV_W)) u_acc (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_en     (scale_valid),
        .step_offset (step_offset),
        .cfg_carrier (cfg_carrier),
        .phase_q     (phase_acc),
        .addr_q      (rom_addr),
        .addr_valid  (rom_en)
    );

    // One table per waveform kind: index 0 sine, index 1 cosine.
    for (genvar g = 0; g < N_WAVES; g++) begin : g_wave
        fmmod_wave_rom #(
            .ADDR_W    (ADDR_W),
            .AMP_W     (AMP_W),
            .AMP_SCALE (AMP_SCALE),
            .KIND      ((g == 0) ? WAVE_SIN : WAVE_COS)
        ) u_rom (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd_en   (rom_en),
            .rd_addr (rom_addr),
            .rd_data (wave_q[g])
        );
    end

    // Output strobe aligned with the registered table read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= rom_en;
        end
    end

    assign out_sin = wave_q[0];
    assign out_cos = wave_q[1];

endmodule

// File: rtl/fmmod_checker.sv
// Cycle-level properties of the FM modulator, bound to the top module.
module fmmod_checker #(
    parameter int DEV_W     = 24,
    parameter int PHASE_W   = 32,
    parameter int AMP_W     = 12,
    parameter int AMP_SCALE = 1024
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic                  out_valid,
    input logic [AMP_W-1:0]      out_sin,
    input logic [AMP_W-1:0]      out_cos,
    input logic [DEV_W-1:0]      cfg_dev,
    input logic                  scale_valid,
    input logic [PHASE_W-1:0]    phase_acc,
    input logic [DEV_W:0]        step_offset
);

    localparam int RING_HI = AMP_SCALE * AMP_SCALE;
    localparam int RING_LO = (AMP_SCALE - 2) * (AMP_SCALE - 2);

    logic [1:0]         since_rst;
    logic signed [31:0] s_ext;
    logic signed [31:0] c_ext;
    logic signed [31:0] radius_sq;
    logic signed [DEV_W:0] off_s;
    logic signed [DEV_W:0] lim_s;

    // Count cycles since reset, saturating at three.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    // Squared radius of the output pair and signed views of the offset.
    always_comb begin
        s_ext     = {{(32-AMP_W){out_sin[AMP_W-1]}}, out_sin};
        c_ext     = {{(32-AMP_W){out_cos[AMP_W-1]}}, out_cos};
        radius_sq = s_ext * s_ext + c_ext * c_ext;
        off_s     = step_offset;
        lim_s     = {1'b0, cfg_dev};
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));           // R2
    AST_OFFSET_CLIPPED: assert property (@(posedge clk) disable iff (!rst_n)
        scale_valid |-> ((off_s <= lim_s) && (off_s >= -lim_s)));           // R6
    AST_PHASE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !scale_valid |=> $stable(phase_acc));                                 // R7
    AST_OUTPUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_sin) && $stable(out_cos)));               // R9
    AST_ON_RING: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((radius_sq <= RING_HI) && (radius_sq >= RING_LO)));    // R3 R4

endmodule

bind fm_modulator_core fmmod_checker #(
    .DEV_W     (DEV_W),
    .PHASE_W   (PHASE_W),
    .AMP_W     (AMP_W),
    .AMP_SCALE (AMP_SCALE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .out_valid   (out_valid),
    .out_sin     (out_sin),
    .out_cos     (out_cos),
    .cfg_dev     (cfg_dev),
    .scale_valid (scale_valid),
    .phase_acc   (phase_acc),
    .step_offset (step_offset)
);

// File: tb/sim_fm_modulator_core.sv
// Self-checking bench: full sweeps of the 12-bit sample range under several
// settings, plus a walk through every table address, against an arithmetic model.
module sim_fm_modulator_core;

    localparam real PI_R = 3.141592653589793;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [11:0] in_sample = '0;
    logic [31:0] cfg_carrier = '0;
    logic [3:0]  cfg_kf = '0;
    logic [23:0] cfg_dev = '0;
    logic        out_valid;
    logic [11:0] out_sin;
    logic [11:0] out_cos;

    int     n_chk = 0;
    int     n_bad = 0;
    bit     finished = 1'b0;
    longint model_phase = 0;
    int     exp_s [$];
    int     exp_c [$];
    bit     h1 = 0, h2 = 0, h3 = 0;
    int     last_s = 0, last_c = 0;
    bit     first_out = 0;

    always #4 clk = ~clk;

    fm_modulator_core u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_sample   (in_sample),
        .cfg_carrier (cfg_carrier),
        .cfg_kf      (cfg_kf),
        .cfg_dev     (cfg_dev),
        .out_valid   (out_valid),
        .out_sin     (out_sin),
        .out_cos     (out_cos)
    );

    function automatic int ref_sin(int a);
        return $rtoi(1024.0 * $sin(2.0 * PI_R * real'(a) / 1024.0));
    endfunction

    function automatic int ref_cos(int a);
        return $rtoi(1024.0 * $cos(2.0 * PI_R * real'(a) / 1024.0));
    endfunction

    // R5 R6: scaled, gained and clipped frequency offset.
    function automatic longint ref_offset(int x, int kf, int dev);
        longint p;
        p = longint'(x) * longint'(dev);
        p = p >>> 11;
        p = p * kf;
        if (p > dev)  p = dev;
        if (p < -dev) p = -dev;
        return p;
    endfunction

    task automatic check_eq(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One cycle: check outputs at the negedge, then drive the next input.
    task automatic step(bit v, int x, string tag);
        int a_s, a_c;
        @(negedge clk);
        check_eq("R2 out_valid latency", int'(out_valid), int'(h3));
        a_s = int'($signed(out_sin));
        a_c = int'($signed(out_cos));
        if (out_valid) begin
            if (exp_s.size() == 0) begin
                check_eq("R2 unexpected output", 1, 0);
            end else begin
                int es, ec;
                es = exp_s.pop_front();
                ec = exp_c.pop_front();
                check_eq({tag, " sin"}, a_s, es);
                check_eq({tag, " cos"}, a_c, ec);
                if (first_out) begin
                    check_eq("R1 first sin", a_s, 0);
                    check_eq("R1 first cos", a_c, 1024);
                    first_out = 0;
                end
            end
            last_s = a_s;
            last_c = a_c;
        end else begin
            check_eq("R9 sin hold", a_s, last_s);
            check_eq("R9 cos hold", a_c, last_c);
        end
        in_valid  = v;
        in_sample = 12'(x);
        if (v) begin
            int addr;
            addr = int'((model_phase >> 22) & 1023);
            exp_s.push_back(ref_sin(addr));
            exp_c.push_back(ref_cos(addr));
            model_phase = (model_phase + longint'(cfg_carrier)
                           + ref_offset(x, int'(cfg_kf), int'(cfg_dev))) & 64'hFFFF_FFFF;
        end
        h3 = h2;
        h2 = h1;
        h1 = v;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check_eq("R1 reset out_valid", int'(out_valid), 0);
        check_eq("R1 reset sin", int'(out_sin), 0);
        check_eq("R1 reset cos", int'(out_cos), 0);
        exp_s.delete();
        exp_c.delete();
        model_phase = 0;
        h1 = 0; h2 = 0; h3 = 0;
        last_s = 0; last_c = 0;
        first_out = 1;
        rst_n = 1'b1;
    endtask

    // Run one configuration; gaps selects a pattern of idle cycles (R7).
    task automatic run_cfg(logic [31:0] car, logic [3:0] kf, logic [23:0] dev,
                           bit gaps, bit scramble, int count, string tag);
        int sent;
        int i;
        do_reset();
        cfg_carrier = car;
        cfg_kf      = kf;
        cfg_dev     = dev;
        sent = 0;
        i = 0;
        while (sent < count) begin
            bit v;
            int x;
            v = !gaps || (((i % 7) != 3) && ((i % 5) != 1));
            if (v) begin
                x = scramble ? (((sent * 1237) % 4096) - 2048) : ((sent % 4096) - 2048);
                sent++;
            end else begin
                x = ((i * 911) % 4096) - 2048;
            end
            step(v, x, tag);
            i++;
        end
        repeat (5) step(1'b0, 0, tag);
        check_eq("R2 all outputs delivered", exp_s.size(), 0);
    endtask

    initial begin
        // R5 R8: every sample value, moderate deviation, no gaps.
        run_cfg(32'h0100_0000, 4'd1, 24'h00_4000, 1'b0, 1'b0, 4096, "R5 R8 sweep");
        // R6 R7: gain of 3 drives the clip; gaps between samples.
        run_cfg(32'h0765_4321, 4'd3, 24'h01_2345, 1'b1, 1'b1, 4096, "R6 R7 clip gaps");
        // R5 R6: largest gain and deviation, carrier near wraparound.
        run_cfg(32'hFFF0_0000, 4'd15, 24'hFF_FFFF, 1'b1, 1'b0, 4096, "R5 R6 wrap");
        // R3 R4: zero gain, carrier of one address per sample walks all entries.
        run_cfg(32'h0040_0000, 4'd0, 24'h00_0100, 1'b0, 1'b1, 1100, "R3 R4 table walk");
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule